// File: doc/BRIEF.md
# Zone-Protected TLB Lookup Unit

This block maps a 32-bit virtual address to a physical address. It holds 64 translation entries and searches all of them at once. Each entry covers one page, and the page size is set per entry as 1 KiB times a power of four. An entry can belong to one process or be shared by all processes. Access rights come from the entry's write and execute flags. A 2-bit zone type, read from a 32-bit zone register, can deny an access or can lift the entry's own flags.

A request carries the address, the access kind, the privilege mode, the current process ID and the zone register. The search begins at the entry that produced the last hit and wraps around the table, so the first qualifying entry in that order wins. A registered response follows. It carries a hit flag and the physical address. It also carries a byte-order-reverse flag and a fault code that tells a miss from a zone fault and from a permission fault. Software loads entries through a separate write port that takes an index and a 64-bit entry word.

Top module: `ztlb_lookup`

## Requirements
- R1: After reset the response outputs are zero and every entry is invalid, so any lookup misses with fault code 22.
- R2: An entry with size code s has a page of 2^(10+2s) bytes. It matches only if its valid bit is set and its tag, placed at address bits 31:10, equals the virtual address on every bit above the page offset. Tag bits inside the page offset are ignored.
- R3: A process field of 0 matches any current process ID. Any other value must equal the current process ID.
- R4: On a hit the physical address is (RPN << 10) plus the virtual address masked to the page size, taken modulo 2^32. On a miss it is 0.
- R5: The zone type is the 2-bit field of the zone register at bits 31-2z down to 30-2z, where z is the entry's zone select. Zone type 0 refuses every user-mode access.
- R6: The entry's write flag must be set for stores and its execute flag for executes, when the zone type is below 3 in user mode or below 2 in supervisor mode. In all other zone types those flags are ignored.
- R7: An execute access to an entry whose guarded bit is set is always refused.
- R8: A hit gives fault code 0. A failed lookup gives 16, plus 2 if no entry matched on valid, process and tag, plus 4 if no such entry also passed the zone check. Bit 0 is then set for execute accesses, giving 22/20/16 or 23/21/17.
- R9: The search starts at the index of the last hit and proceeds upward, wrapping modulo 64. The first entry that passes every check wins. Every hit moves the start to the winning index, and a miss leaves it in place.
- R10: The endian output equals the winning entry's endian bit for load and store. It is 0 for execute and on a miss.
- R11: The response appears one clock after the request and rsp_valid follows lk_req by one clock. An entry write lands at the clock edge, so a lookup in the same cycle still sees the old entry.
- R12: Access codes: 0 load, 1 store, 2 execute, 3 treated as load. Entry word bits: 63 valid, 62:55 process, 54:33 tag, 32:30 size, 29:26 zone select, 25:4 RPN, 3 write, 2 execute, 1 guarded, 0 endian.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write one entry this cycle |
| wr_idx | input | 6 | Entry index to write |
| wr_data | input | 64 | Entry word (layout in R12) |
| lk_req | input | 1 | Lookup request this cycle |
| lk_va | input | 32 | Virtual address |
| lk_acc | input | 2 | Access kind (R12) |
| lk_user | input | 1 | 1 = user mode, 0 = supervisor |
| lk_pid | input | 8 | Current process ID |
| lk_zpr | input | 32 | Zone protection register |
| rsp_valid | output | 1 | Response valid |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_pa | output | 32 | Physical address |
| rsp_endian | output | 1 | Reverse byte order for this access |
| rsp_fault | output | 5 | Fault code (R8) |

## Verification
Each lookup is driven on a falling edge and held for one clock. The compare and the rotating pick settle within that cycle, and the next rising edge registers the result. The bench therefore samples every response output on the following falling edge, exactly one clock after the request. An entry write is likewise driven on a falling edge and lands on the next rising edge. One test drives a write and a lookup of the same address in the same cycle and expects a miss, then expects a hit on the next request. Sweeps over page size, zone type, privilege, access kind and flag settings compare each result with codes computed arithmetically from the rules.

// File: rtl/ztlb_pkg.sv
package ztlb_pkg;
  localparam int VA_W    = 32;
  localparam int PID_W   = 8;
  localparam int OFF_MIN = 10;
  localparam int TAG_W   = VA_W - OFF_MIN;
  localparam int RPN_W   = VA_W - OFF_MIN;
  localparam int SIZE_W  = 3;
  localparam int ZSEL_W  = 4;
  localparam int FLT_W   = 5;
  localparam int ENTRY_W = 1 + PID_W + TAG_W + SIZE_W + ZSEL_W + RPN_W + 4;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef struct packed {
    logic              vld;
    logic [PID_W-1:0]  tid;
    logic [TAG_W-1:0]  tag;
    logic [SIZE_W-1:0] size;
    logic [ZSEL_W-1:0] zsel;
    logic [RPN_W-1:0]  rpn;
    logic              wr;
    logic              ex;
    logic              grd;
    logic              endn;
  } tlb_entry_t;

  function automatic logic [VA_W-1:0] page_mask(input logic [SIZE_W-1:0] sz);
    return (VA_W'(1) << (OFF_MIN + 2 * int'(sz))) - VA_W'(1);
  endfunction
endpackage

// File: rtl/ztlb_entry_match.sv
module ztlb_entry_match
  import ztlb_pkg::*;
(
  input  tlb_entry_t       ent,
  input  logic [VA_W-1:0]  va,
  input  logic [PID_W-1:0] pid,
  input  logic [VA_W-1:0]  zpr,
  input  logic             user,
  input  logic [1:0]       acc,
  output logic             base_m,
  output logic             zone_m,
  output logic             full_m
);
  logic [VA_W-1:0] msk;
  logic [VA_W-1:0] zsh;
  logic [1:0]      ztype;
  logic            tag_ok, tid_ok, zone_ok, enforce, perm_ok;
  logic            is_st, is_ex;

  always_comb begin
    msk     = page_mask(ent.size);
    tag_ok  = (((va ^ {ent.tag, {OFF_MIN{1'b0}}}) & ~msk) == '0);
    tid_ok  = (ent.tid == '0) || (ent.tid == pid);
    base_m  = ent.vld && tid_ok && tag_ok;
    zsh     = zpr >> (6'd30 - {1'b0, ent.zsel, 1'b0});
    ztype   = zsh[1:0];
    zone_ok = !(ztype == 2'd0 && user);
    enforce = user ? (ztype != 2'd3) : (ztype < 2'd2);
    is_st   = (acc == ACC_STORE);
    is_ex   = (acc == ACC_EXEC);
    perm_ok = !(enforce && ((is_st && !ent.wr) || (is_ex && !ent.ex)))
              && !(is_ex && ent.grd);
    zone_m  = base_m && zone_ok;
    full_m  = zone_m && perm_ok;
  end
endmodule

// File: rtl/ztlb_rot_pick.sv
module ztlb_rot_pick #(
  parameter int N     = 64,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req,
  input  logic [IDX_W-1:0] base,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  logic [2*N-1:0]   dbl;
  logic [N-1:0]     rot;
  logic [IDX_W-1:0] off;

  always_comb begin
    dbl   = {req, req} >> base;
    rot   = dbl[N-1:0];
    found = |rot;
    off   = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (rot[k]) off = IDX_W'(k);
    end
    idx = off + base;
  end
endmodule

// File: rtl/ztlb_lookup.sv
module ztlb_lookup
  import ztlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [ENTRY_W-1:0] wr_data,
  input  logic               lk_req,
  input  logic [VA_W-1:0]    lk_va,
  input  logic [1:0]         lk_acc,
  input  logic               lk_user,
  input  logic [PID_W-1:0]   lk_pid,
  input  logic [VA_W-1:0]    lk_zpr,
  output logic               rsp_valid,
  output logic               rsp_hit,
  output logic [VA_W-1:0]    rsp_pa,
  output logic               rsp_endian,
  output logic [FLT_W-1:0]   rsp_fault
);
  tlb_entry_t       ent_q [ENTRIES];
  logic [IDX_W-1:0] last_q;
  logic [ENTRIES-1:0] base_v, zone_v, full_v;
  logic             pick_found;
  logic [IDX_W-1:0] pick_idx;
  logic [RPN_W-1:0] sel_rpn;
  logic [SIZE_W-1:0] sel_size;
  logic             sel_endn;
  logic [VA_W-1:0]  pa_c;
  logic [FLT_W-1:0] fault_c;
  logic             is_ex;

  // Entry storage: only the valid bits are reset.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) ent_q[i].vld <= 1'b0;
    end else if (wr_en) begin
      ent_q[wr_idx] <= tlb_entry_t'(wr_data);
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    ztlb_entry_match u_match (
      .ent    (ent_q[g]),
      .va     (lk_va),
      .pid    (lk_pid),
      .zpr    (lk_zpr),
      .user   (lk_user),
      .acc    (lk_acc),
      .base_m (base_v[g]),
      .zone_m (zone_v[g]),
      .full_m (full_v[g])
    );
  end

  ztlb_rot_pick #(.N(ENTRIES), .IDX_W(IDX_W)) u_pick (
    .req   (full_v),
    .base  (last_q),
    .found (pick_found),
    .idx   (pick_idx)
  );

  always_comb begin
    sel_rpn  = ent_q[pick_idx].rpn;
    sel_size = ent_q[pick_idx].size;
    sel_endn = ent_q[pick_idx].endn;
    is_ex    = (lk_acc == ACC_EXEC);
    pa_c     = {sel_rpn, {OFF_MIN{1'b0}}} + (lk_va & page_mask(sel_size));
    if (pick_found) fault_c = '0;
    else            fault_c = {1'b1, 1'b0, ~|zone_v, ~|base_v, is_ex};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_pa     <= '0;
      rsp_endian <= 1'b0;
      rsp_fault  <= '0;
      last_q     <= '0;
    end else begin
      rsp_valid <= lk_req;
      if (lk_req) begin
        rsp_hit    <= pick_found;
        rsp_pa     <= pick_found ? pa_c : '0;
        rsp_endian <= pick_found && sel_endn && !is_ex;
        rsp_fault  <= fault_c;
        if (pick_found) last_q <= pick_idx;
      end
    end
  end

  // Assertions
  assert_resp_follows_req_R11: assert property (@(posedge clk) disable iff (rst)
    lk_req |=> rsp_valid);
  assert_idle_no_resp_R11: assert property (@(posedge clk) disable iff (rst)
    !lk_req |=> !rsp_valid);
  assert_hit_code_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_hit) |-> (rsp_fault == '0));
  assert_fault_form_R8: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit) |-> (rsp_fault[4] && !(rsp_fault[1] && !rsp_fault[2])));
  assert_exec_no_endian_R10: assert property (@(posedge clk) disable iff (rst)
    (lk_req && lk_acc == ACC_EXEC) |=> !rsp_endian);
  assert_pick_qualifies_R9: assert property (@(posedge clk) disable iff (rst)
    (lk_req && pick_found) |-> full_v[pick_idx]);
  assert_start_priority_R9: assert property (@(posedge clk) disable iff (rst)
    (lk_req && full_v[last_q]) |-> (pick_idx == last_q));
endmodule

// File: tb/ztlb_lookup_bench.sv
module ztlb_lookup_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_idx = '0;
  logic [63:0] wr_data = '0;
  logic        lk_req = 1'b0;
  logic [31:0] lk_va = '0;
  logic [1:0]  lk_acc = '0;
  logic        lk_user = 1'b0;
  logic [7:0]  lk_pid = '0;
  logic [31:0] lk_zpr = '0;
  logic        rsp_valid, rsp_hit, rsp_endian;
  logic [31:0] rsp_pa;
  logic [4:0]  rsp_fault;
  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  ztlb_lookup u_ztlb_lookup (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .lk_req(lk_req), .lk_va(lk_va), .lk_acc(lk_acc), .lk_user(lk_user),
    .lk_pid(lk_pid), .lk_zpr(lk_zpr), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_pa(rsp_pa), .rsp_endian(rsp_endian), .rsp_fault(rsp_fault)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(input logic v, input logic [7:0] tid,
      input logic [21:0] tag, input logic [2:0] sz, input logic [3:0] zs,
      input logic [21:0] rpn, input logic w, input logic x, input logic g,
      input logic e);
    return {v, tid, tag, sz, zs, rpn, w, x, g, e};
  endfunction

  function automatic logic [4:0] exp_code(input int zt, input int usr, input int acc,
      input int w, input int x, input int g);
    logic [4:0] xb;
    int enf;
    xb = (acc == 2) ? 5'd1 : 5'd0;
    if (zt == 0 && usr == 1) return 5'd20 | xb;
    enf = (usr == 1) ? (zt < 3) : (zt < 2);
    if (enf != 0 && ((acc == 1 && w == 0) || (acc == 2 && x == 0))) return 5'd16 | xb;
    if (acc == 2 && g == 1) return 5'd16 | xb;
    return 5'd0;
  endfunction

  task automatic wr(input int idx, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 6'(idx); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic look(input logic [31:0] va, input int acc, input int usr,
      input int pid, input logic [31:0] zpr);
    @(negedge clk);
    lk_req = 1'b1; lk_va = va; lk_acc = 2'(acc); lk_user = 1'(usr);
    lk_pid = 8'(pid); lk_zpr = zpr;
    @(negedge clk);
    lk_req = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R11 actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] m, vb, vin, zp;
    logic [4:0]  ec;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1 valid idle", {31'd0, rsp_valid}, 32'd0);
    chk("R1 pa", rsp_pa, 32'd0);
    chk("R1 fault", {27'd0, rsp_fault}, 32'd0);
    look(32'h1234_5678, 0, 0, 0, 32'hFFFF_FFFF);
    chk("R1 miss after reset", {27'd0, rsp_fault}, 32'd22);
    chk("R11 rsp_valid", {31'd0, rsp_valid}, 32'd1);
    @(negedge clk);
    chk("R11 rsp_valid drops", {31'd0, rsp_valid}, 32'd0);

    // R2/R4: page size sweep, tag bits inside offset ignored
    for (int s = 0; s < 8; s++) begin
      m  = (32'd1 << (10 + 2 * s)) - 32'd1;
      vb = {22'h2A5A5A, 10'd0} & ~m;
      wr(0, mk(1'b1, 8'd0, 22'h2A5A5A, 3'(s), 4'd0, 22'h0F0F1 + 22'(s), 1, 1, 0, 0));
      vin = vb | (32'h00C3_A5F7 & m);
      look(vin, 0, 0, 0, 32'hFFFF_FFFF);
      chk($sformatf("R2 hit size %0d", s), {31'd0, rsp_hit}, 32'd1);
      chk($sformatf("R4 pa size %0d", s), rsp_pa,
          ({22'h0F0F1 + 22'(s), 10'd0}) + (vin & m));
      look(vb ^ (32'd1 << (10 + 2 * s)), 0, 0, 0, 32'hFFFF_FFFF);
      chk($sformatf("R2 miss beyond page %0d", s), {27'd0, rsp_fault}, 32'd22);
      chk($sformatf("R4 pa zero on miss %0d", s), rsp_pa, 32'd0);
    end

    // R3: process matching
    wr(0, mk(1'b1, 8'd0, 22'h00100, 3'd0, 4'd0, 22'h00200, 1, 1, 0, 0));
    look(32'h0004_0010, 0, 0, 77, 32'hFFFF_FFFF);
    chk("R3 global entry any pid", {31'd0, rsp_hit}, 32'd1);
    wr(0, mk(1'b1, 8'd9, 22'h00100, 3'd0, 4'd0, 22'h00200, 1, 1, 0, 0));
    look(32'h0004_0010, 0, 0, 9, 32'hFFFF_FFFF);
    chk("R3 pid equal hit", {31'd0, rsp_hit}, 32'd1);
    look(32'h0004_0010, 2, 0, 10, 32'hFFFF_FFFF);
    chk("R3 pid differ miss exec", {27'd0, rsp_fault}, 32'd23);

    // R5: zone field position sweep
    for (int z = 0; z < 16; z++) begin
      zp = ~(32'h3 << (30 - 2 * z));
      wr(0, mk(1'b1, 8'd0, 22'h00100, 3'd0, 4'(z), 22'h00200, 1, 1, 0, 0));
      look(32'h0004_0010, 0, 1, 0, zp);
      chk($sformatf("R5 zone %0d user denied", z), {27'd0, rsp_fault}, 32'd20);
      wr(0, mk(1'b1, 8'd0, 22'h00100, 3'd0, 4'((z + 1) % 16), 22'h00200, 1, 1, 0, 0));
      look(32'h0004_0010, 0, 1, 0, zp);
      chk($sformatf("R5 neighbour zone %0d hit", z), {31'd0, rsp_hit}, 32'd1);
    end

    // R6/R7/R8/R10: zone type x mode x access x flags
    for (int zt = 0; zt < 4; zt++)
      for (int u = 0; u < 2; u++)
        for (int a = 0; a < 3; a++)
          for (int f = 0; f < 8; f++) begin
            zp = (32'(~zt & 3) * 32'h5555_5555) & ~(32'h3 << 20);
            zp = zp | (32'(zt) << 20);
            wr(1, mk(1'b1, 8'd0, 22'h03000, 3'd0, 4'd5, 22'h00077,
                     f[0], f[1], f[2], 1'b1));
            look(32'h00C0_0123, a, u, 0, zp);
            ec = exp_code(zt, u, a, f[0], f[1], f[2]);
            chk($sformatf("R6 R7 R8 code zt%0d u%0d a%0d f%0d", zt, u, a, f),
                {27'd0, rsp_fault}, {27'd0, ec});
            chk($sformatf("R10 endian zt%0d u%0d a%0d f%0d", zt, u, a, f),
                {31'd0, rsp_endian}, {31'd0, (ec == 5'd0 && a != 2)});
          end
    wr(1, mk(1'b1, 8'd0, 22'h03000, 3'd0, 4'd5, 22'h00077, 1, 1, 0, 0));
    look(32'h00C0_0123, 3, 0, 0, 32'hFFFF_FFFF);
    chk("R10 endian bit clear", {31'd0, rsp_endian}, 32'd0);
    chk("R12 access 3 as load pa", rsp_pa, 32'h0001_DD23);
    wr(1, 64'd0);
    wr(0, 64'd0);

    // R11: write in same cycle as lookup
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 6'd7;
    wr_data = mk(1'b1, 8'd0, 22'h10000, 3'd0, 4'd0, 22'h00033, 1, 1, 0, 0);
    lk_req = 1'b1; lk_va = 32'h0400_0008; lk_acc = 2'd0; lk_user = 1'b0;
    lk_pid = 8'd0; lk_zpr = 32'hFFFF_FFFF;
    @(negedge clk);
    wr_en = 1'b0; lk_req = 1'b0;
    chk("R11 same-cycle write unseen", {27'd0, rsp_fault}, 32'd22);
    look(32'h0400_0008, 0, 0, 0, 32'hFFFF_FFFF);
    chk("R11 write seen next", rsp_pa, 32'h0000_CC08);
    wr(7, 64'd0);

    // R9: rotating search
    wr(40, mk(1'b1, 8'd3, 22'h100000, 3'd1, 4'd0, 22'h00040, 1, 1, 0, 0));
    wr(5,  mk(1'b1, 8'd0, 22'h100000, 3'd0, 4'd0, 22'h00005, 1, 1, 0, 0));
    look(32'h4000_0800, 0, 0, 3, 32'hFFFF_FFFF);
    chk("R9 only entry 40", rsp_pa, 32'h0001_0800);
    look(32'h4000_0100, 0, 0, 3, 32'hFFFF_FFFF);
    chk("R9 start at 40", rsp_pa, 32'h0001_0100);
    look(32'h4000_0100, 0, 0, 4, 32'hFFFF_FFFF);
    chk("R9 only entry 5", rsp_pa, 32'h0000_1500);
    look(32'h7000_0000, 0, 0, 3, 32'hFFFF_FFFF);
    chk("R9 miss between", {27'd0, rsp_fault}, 32'd22);
    look(32'h4000_0100, 0, 0, 3, 32'hFFFF_FFFF);
    chk("R9 start moved to 5, kept over miss", rsp_pa, 32'h0000_1500);
    wr(5, 64'd0);
    wr(3,  mk(1'b1, 8'd0, 22'h100000, 3'd0, 4'd0, 22'h00003, 1, 1, 0, 0));
    wr(45, mk(1'b1, 8'd0, 22'h100000, 3'd0, 4'd0, 22'h0002D, 1, 1, 0, 0));
    look(32'h4000_0800, 0, 0, 3, 32'hFFFF_FFFF);
    wr(40, 64'd0);
    look(32'h4000_0100, 0, 0, 3, 32'hFFFF_FFFF);
    chk("R9 upward from 40 picks 45", rsp_pa, 32'h0000_B500);
    wr(50, mk(1'b1, 8'd3, 22'h100000, 3'd1, 4'd0, 22'h00050, 1, 1, 0, 0));
    look(32'h4000_0800, 0, 0, 3, 32'hFFFF_FFFF);
    chk("R9 only entry 50", rsp_pa, 32'h0001_4800);
    wr(50, 64'd0);
    look(32'h4000_0100, 0, 0, 3, 32'hFFFF_FFFF);
    chk("R9 wrap from 50 picks 3", rsp_pa, 32'h0000_0D00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule